// File: doc/BRIEF.md
# SPI Flash Single-Byte PIO Read Engine

This block reads a serial NOR flash one byte per software trigger. Software first loads a start address and a read mode through a small byte-wide configuration port. The address lives in four byte registers, the mode in a mode register, and there is a fast-read enable and two opcode registers. Each pulse on `go` then runs one complete flash transaction. The transaction sends the opcode, then a 24-bit or 32-bit address, then optional dummy clocks, and finally captures one data byte on one, two or four lines.

When the byte arrives, chip select is released and the byte appears on `rd_byte`. A one-cycle `done` pulse marks completion, and the internal address pointer advances by one. Software can therefore walk through consecutive flash bytes by issuing triggers alone. `busy` stays high for the whole transaction and plays the role of a self-clearing command bit.

The serial clock runs at half the system clock in SPI mode 0. The engine changes outputs while `sf_sck` is low, and it samples input lines at the end of each high phase.

Top module: `spi_pio_reader`

## Requirements
- R1: After reset `sf_cs_n` is 1, `sf_sck` is 0, `busy` and `done` are 0, `rd_byte` is 0x00 and `cur_addr` is 0x00000000.
- R2: While idle, a write with `cfg_we` loads the register picked by `cfg_sel`: 0 to 3 are address bytes from least to most significant (visible on `cur_addr`), 4 is the mode register, 5 bit 0 is fast-read enable, 6 is the single/dual opcode and 7 is the quad opcode. Writes made while `busy` is 1 are dropped.
- R3: A transaction drives `sf_cs_n` low, then shifts the opcode and then the address, most significant bit first, on `sf_io_o[0]` with `sf_io_oe[0]` set. Each bit is valid at a rising edge of `sf_sck`. The address is 24 bits (`cur_addr[23:0]`) when mode bit 4 is 0 and 32 bits when mode bit 4 is 1.
- R4: The opcode comes from register 7 when mode bit 2 is set, and from register 6 otherwise.
- R5: Exactly 8 dummy clocks follow the address when fast-read is enabled, when mode bit 0 is set, or when mode bit 2 is set. With none of these set, data follows the address directly.
- R6: The data byte is captured most significant bit first. With mode bits 0 and 2 clear it takes 8 clocks on `sf_io_i[1]`. With only bit 0 set it takes 4 clocks of `{sf_io_i[1], sf_io_i[0]}`. With bit 2 set, whatever bit 0 holds, it takes 2 clocks of `sf_io_i[3:0]`.
- R7: On the cycle the transaction ends, `sf_cs_n` returns to 1, `busy` falls, `done` pulses for one cycle and `rd_byte` holds the captured byte. The clock stays low whenever chip select is high.
- R8: Each completed byte advances `cur_addr` by one. In 4-byte mode all 32 bits wrap together. In 3-byte mode only the low 24 bits wrap, and byte 3 is left unchanged.
- R9: A `go` pulse that arrives while `busy` is 1 starts no further transaction. The pointer stays stable during a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| go | input | 1 | Start one single-byte read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Last byte read |
| cur_addr | output | 32 | Current address pointer |
| sf_sck | output | 1 | Serial clock to flash |
| sf_cs_n | output | 1 | Flash chip select, active low |
| sf_io_o | output | 4 | Serial data out |
| sf_io_oe | output | 4 | Output enables for serial lines |
| sf_io_i | input | 4 | Serial data in |

## Verification
A flash model in the bench records every header bit and counts serial clocks. For each read, the bench checks the opcode, the address field width, the dummy gap and the lane count against the requirements. Plain single-line reads and fast single-line reads differ only by the dummy gap. Dual and quad reads expose lane order and clock count, and a quad read with the dual bit also set shows which mode wins and which opcode register is used. Reads at 0x12FFFFFF in 3-byte mode and at 0xFFFFFFFF in 4-byte mode separate the two wrap rules. A back-to-back sequence shows the header tracking the advancing pointer. Configuration writes and triggers applied mid-transfer show that both are dropped.

// File: rtl/spi_pio_reader.sv
module spi_pio_reader #(
  parameter int DUMMY_CLKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  input  logic        go,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rd_byte,
  output logic [31:0] cur_addr,
  output logic        sf_sck,
  output logic        sf_cs_n,
  output logic [3:0]  sf_io_o,
  output logic [3:0]  sf_io_oe,
  input  logic [3:0]  sf_io_i
);
  localparam int CW = 6;
  localparam logic [CW-1:0] DUM_N = CW'(DUMMY_CLKS);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DUMMY, S_DATA} st_t;
  st_t st;

  logic [31:0] ptr;
  logic        m_dual, m_quad, m_wide, fast_q;
  logic [7:0]  op_std, op_quad;
  logic [39:0] tx;
  logic [CW-1:0] cnt;
  logic [7:0]  rx, rd_q;
  logic        sck_q, cs_q, done_q;

  wire use_quad   = m_quad;
  wire use_dual   = m_dual & ~m_quad;
  wire need_dummy = (fast_q | m_dual | m_quad) && (DUMMY_CLKS != 0);
  wire [CW-1:0] hdr_clks  = m_wide ? CW'(40) : CW'(32);
  wire [CW-1:0] data_clks = use_quad ? CW'(2) : use_dual ? CW'(4) : CW'(8);
  wire [7:0] opc = use_quad ? op_quad : op_std;
  wire [7:0] rx_next = use_quad ? {rx[3:0], sf_io_i[3:0]} :
                       use_dual ? {rx[5:0], sf_io_i[1:0]} :
                                  {rx[6:0], sf_io_i[1]};
  wire [31:0] ptr_inc = m_wide ? ptr + 32'd1 : {ptr[31:24], ptr[23:0] + 24'd1};
  wire last = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0;
      m_dual <= 1'b0;
      m_quad <= 1'b0;
      m_wide <= 1'b0;
      fast_q <= 1'b0;
      op_std <= '0;
      op_quad <= '0;
      tx <= '0;
      cnt <= '0;
      rx <= '0;
      rd_q <= '0;
      sck_q <= 1'b0;
      cs_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        sck_q <= 1'b0;
        if (cfg_we) begin
          case (cfg_sel)
            3'd0: ptr[7:0]   <= cfg_wdata;
            3'd1: ptr[15:8]  <= cfg_wdata;
            3'd2: ptr[23:16] <= cfg_wdata;
            3'd3: ptr[31:24] <= cfg_wdata;
            3'd4: begin
              m_dual <= cfg_wdata[0];
              m_quad <= cfg_wdata[2];
              m_wide <= cfg_wdata[4];
            end
            3'd5: fast_q <= cfg_wdata[0];
            3'd6: op_std <= cfg_wdata;
            default: op_quad <= cfg_wdata;
          endcase
        end else if (go) begin
          cs_q <= 1'b0;
          st <= S_HDR;
          cnt <= hdr_clks;
          tx <= m_wide ? {opc, ptr} : {opc, ptr[23:0], 8'h00};
        end
      end else begin
        sck_q <= ~sck_q;
        if (sck_q) begin
          cnt <= cnt - CW'(1);
          if (st == S_HDR) tx <= {tx[38:0], 1'b0};
          if (st == S_DATA) rx <= rx_next;
          if (last) begin
            case (st)
              S_HDR: begin
                if (need_dummy) begin
                  st <= S_DUMMY;
                  cnt <= DUM_N;
                end else begin
                  st <= S_DATA;
                  cnt <= data_clks;
                end
              end
              S_DUMMY: begin
                st <= S_DATA;
                cnt <= data_clks;
              end
              default: begin
                st <= S_IDLE;
                cs_q <= 1'b1;
                rd_q <= rx_next;
                ptr <= ptr_inc;
                done_q <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign rd_byte  = rd_q;
  assign cur_addr = ptr;
  assign sf_sck   = sck_q;
  assign sf_cs_n  = cs_q;
  assign sf_io_o  = {3'b000, tx[39]};
  assign sf_io_oe = {3'b000, st == S_HDR};
endmodule

// File: rtl/spi_pio_reader_chk.sv
module spi_pio_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [31:0] cur_addr,
  input logic        sf_sck,
  input logic        sf_cs_n,
  input logic [3:0]  sf_io_oe
);
  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_cs_n |-> !sf_sck);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sf_cs_n && $past(busy)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_addr != $past(cur_addr)));

  // R3
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_io_oe[0] |-> !sf_cs_n);
endmodule

bind spi_pio_reader spi_pio_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cur_addr(cur_addr),
  .sf_sck(sf_sck), .sf_cs_n(sf_cs_n), .sf_io_oe(sf_io_oe)
);

// File: tb/test_spi_pio_reader.sv
module test_spi_pio_reader;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, go = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic busy, done, sf_sck, sf_cs_n;
  logic [7:0] rd_byte;
  logic [31:0] cur_addr;
  logic [3:0] sf_io_o, sf_io_oe;
  logic [3:0] sf_io_i = 0;

  int total = 0, bad = 0;
  int m_hdr = 40, m_lines = 1;
  logic [7:0] m_byte = 0;
  int ntrans = 0, last_rises = 0, last_ncap = 0;
  logic [39:0] last_cap = 0;

  always #4 clk = ~clk;

  spi_pio_reader i_spi_pio_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .go(go), .busy(busy), .done(done),
    .rd_byte(rd_byte), .cur_addr(cur_addr), .sf_sck(sf_sck),
    .sf_cs_n(sf_cs_n), .sf_io_o(sf_io_o), .sf_io_oe(sf_io_oe),
    .sf_io_i(sf_io_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin : flash_model
    forever begin
      int nrise, ncap;
      logic [39:0] cap;
      logic [7:0] dsh;
      @(negedge sf_cs_n);
      nrise = 0; ncap = 0; cap = 0; dsh = m_byte;
      forever begin
        @(posedge sf_sck or posedge sf_cs_n);
        if (sf_cs_n) break;
        nrise++;
        if (sf_io_oe[0]) begin
          cap = {cap[38:0], sf_io_o[0]};
          ncap++;
        end
        @(negedge sf_sck);
        #1;
        if (sf_cs_n) break;
        if (nrise >= m_hdr) begin
          case (m_lines)
            1: begin sf_io_i[1] = dsh[7]; dsh = dsh << 1; end
            2: begin sf_io_i[1:0] = dsh[7:6]; dsh = dsh << 2; end
            default: begin sf_io_i = dsh[7:4]; dsh = dsh << 4; end
          endcase
        end
      end
      last_rises = nrise; last_ncap = ncap; last_cap = cap;
      ntrans++;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) wr(3'(i), a[8*i +: 8]);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, req, "done seen", done, 1);
  endtask

  task automatic one_read(input string req, input logic [7:0] opc, input bit wide,
                          input int dum, input int lines, input logic [7:0] dat);
    logic [31:0] a0, aexp;
    int ab, n0;
    ab = wide ? 32 : 24;
    a0 = cur_addr;
    aexp = wide ? a0 + 1 : {a0[31:24], a0[23:0] + 24'd1};
    m_hdr = 8 + ab + dum; m_lines = lines; m_byte = dat; n0 = ntrans;
    @(negedge clk); go = 1; @(negedge clk); go = 0;
    wait_done(req);
    chk(rd_byte == dat, req, "rd_byte", rd_byte, dat);
    chk(!busy && sf_cs_n, "R7", "idle at done", {busy, sf_cs_n}, 2'b01);
    chk(ntrans == n0 + 1, req, "one frame", ntrans, n0 + 1);
    chk(last_ncap == 8 + ab, "R3", "header bits", last_ncap, 8 + ab);
    chk(8'(last_cap >> ab) == opc, "R4", "opcode", 8'(last_cap >> ab), opc);
    chk((last_cap & ((40'd1 << ab) - 1)) == (wide ? 40'(a0) : 40'(a0[23:0])),
        "R3", "address field", last_cap & ((40'd1 << ab) - 1), a0);
    chk(last_rises == 8 + ab + dum + 8 / lines, "R5", "clock count",
        last_rises, 8 + ab + dum + 8 / lines);
    chk(cur_addr == aexp, "R8", "address advance", cur_addr, aexp);
  endtask

  task automatic t_reset;
    chk(sf_cs_n && !sf_sck && !busy && !done, "R1", "idle pins",
        {sf_cs_n, sf_sck, busy, done}, 4'b1000);
    chk(rd_byte == 0 && cur_addr == 0, "R1", "regs", {rd_byte, cur_addr}, 0);
  endtask

  task automatic t_plain;
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h03); wr(3'd7, 8'h6B);
    set_addr(32'h00123456);
    chk(cur_addr == 32'h00123456, "R2", "address load", cur_addr, 32'h00123456);
    one_read("R6", 8'h03, 0, 0, 1, 8'hA7);
  endtask

  task automatic t_fast;
    wr(3'd5, 8'h01); wr(3'd6, 8'h0B);
    one_read("R5", 8'h0B, 0, 8, 1, 8'h5C);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_dual;
    wr(3'd4, 8'h01); wr(3'd6, 8'h3B);
    one_read("R6", 8'h3B, 0, 8, 2, 8'h96);
  endtask

  task automatic t_quad;
    wr(3'd4, 8'h05);
    one_read("R6", 8'h6B, 0, 8, 4, 8'h3E);
  endtask

  task automatic t_wide;
    wr(3'd4, 8'h10); wr(3'd6, 8'h13);
    set_addr(32'hA1B2C3D4);
    one_read("R3", 8'h13, 1, 0, 1, 8'hC9);
  endtask

  task automatic t_wrap3;
    wr(3'd4, 8'h00);
    set_addr(32'h12FFFFFF);
    one_read("R8", 8'h13, 0, 0, 1, 8'h01);
    chk(cur_addr == 32'h12000000, "R8", "24-bit wrap", cur_addr, 32'h12000000);
  endtask

  task automatic t_wrap4;
    wr(3'd4, 8'h10);
    set_addr(32'hFFFFFFFF);
    one_read("R8", 8'h13, 1, 0, 1, 8'hFE);
    chk(cur_addr == 32'h0, "R8", "32-bit wrap", cur_addr, 32'h0);
  endtask

  task automatic t_seq;
    wr(3'd4, 8'h00);
    set_addr(32'h000000FE);
    for (int i = 0; i < 3; i++) one_read("R8", 8'h13, 0, 0, 1, 8'(8'h40 + i));
    chk(cur_addr == 32'h101, "R8", "after three", cur_addr, 32'h101);
  endtask

  task automatic t_busy;
    int n0;
    wr(3'd4, 8'h00);
    set_addr(32'h00000500);
    n0 = ntrans;
    m_hdr = 32; m_lines = 1; m_byte = 8'h77;
    @(negedge clk); go = 1; @(negedge clk); go = 0;
    repeat (10) @(negedge clk);
    chk(busy, "R9", "busy mid-frame", busy, 1);
    go = 1; cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = 8'hAA;
    @(negedge clk); go = 0; cfg_we = 0;
    cfg_sel = 3'd6; cfg_wdata = 8'h99; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
    wait_done("R9");
    chk(cur_addr == 32'h501, "R2", "write while busy dropped", cur_addr, 32'h501);
    repeat (200) @(negedge clk);
    chk(ntrans == n0 + 1 && sf_cs_n, "R9", "no extra frame", ntrans, n0 + 1);
    one_read("R2", 8'h13, 0, 0, 1, 8'h21);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_plain();
    t_fast();
    t_dual();
    t_quad();
    t_wide();
    t_wrap3();
    t_wrap4();
    t_seq();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule